// File: doc/BRIEF.md
# Gated and Latched Event Scaler Channel

One channel of an event scaler. A selector picks one of 21 single-bit event sources, and the channel counts the rising edges of that source in a saturating counter. A mode word sets how counting is framed. In gated mode the channel counts inside one gate window and then keeps that single total. In latched mode a latch strobe stores the running total in a deep word queue and starts a new interval from zero. Gated-latched mode is latched mode in which counting pauses while the gate is low.

Software reads the channel through a pop port. A read strobe returns the oldest queued word, or the held total in gated mode. A depth output reports how many words can be read. A sticky flag shows that a latch arrived while the queue was full and its value was lost. A one-cycle software reset strobe clears the channel. The shared master reset clears it only when the mode word enables that.

Top module: `evt_scaler_fifo`

## Requirements
- R1: `src_sel_i` values 0 to 20 select bit `src_sel_i` of `src_vec_i` (0–7 front inputs, 8–15 generator outputs, 16–19 combined gates, 20 common input). Values 21 to 31 select no source. Only a rising edge of the selected source (high now, low on the previous clock) adds one to the count.
- R2: Gated mode (`mode_i[2:0]` = 1) counts edges only while `gate_i` is high and holds the count while it is low. A read returns the count without removing it, and `mult_o` is 1.
- R3: In gated mode, once `gate_i` has fallen, later gate windows do not count until a reset clears the channel.
- R4: Latched mode (`mode_i[2:0]` = 2) counts every edge. A `latch_i` cycle stores the count accumulated before that cycle and restarts the count. An edge in the latch cycle becomes the first count of the new interval.
- R5: Gated-latched mode (`mode_i[2:0]` = 3) behaves as in R4, but edges are not counted while `gate_i` is low.
- R6: In the latched modes, a `rd_en_i` cycle removes the oldest stored word, and the word appears on `rd_data_o` after the next clock edge. A read from an empty queue returns 0. `mult_o` equals the number of stored words, up to DEPTH.
- R7: A latch that arrives while DEPTH words are stored drops its value, sets `overflow_o`, and still restarts the count. `overflow_o` stays set until a reset.
- R8: `sw_reset_i` clears the count, the queue, the gate-used state and `overflow_o`. `mreset_i` does the same only when `mode_i[3]` is 1, and it has no effect otherwise.
- R9: The count saturates at its all-ones value and does not wrap.
- R10: Mode values 0 and 4 to 7 of `mode_i[2:0]` are off: no counting, latches ignored, `mult_o` is 0 and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_vec_i | input | NUM_SRC (21) | Candidate event sources |
| src_sel_i | input | SEL_W (5) | Source select code |
| mode_i | input | 4 | [2:0] counting mode, [3] master reset enable |
| gate_i | input | 1 | Gate level |
| latch_i | input | 1 | Latch strobe, one cycle per latch |
| mreset_i | input | 1 | Master reset strobe |
| sw_reset_i | input | 1 | Software reset strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | CNT_W (32) | Read word, valid after the read cycle |
| mult_o | output | $clog2(DEPTH+1) (11) | Number of readable words |
| overflow_o | output | 1 | Sticky lost-latch flag |

## Verification
The assertions assume that the mode word stays fixed between a reset and the use of the count, that a latch is a single-cycle strobe, and that no read is issued in the cycle a reset strobe clears the queue. The bench changes the mode only between operations, with a reset strobe in between. It drives every strobe for exactly one cycle from the falling edge. It also never reads while the queue is full and a latch is pending, so the counter and queue state the properties track stays defined by the requirements.

// File: rtl/scaler_pkg.sv
`timescale 1ns/1ps
package scaler_pkg;
  typedef enum logic [1:0] {
    M_OFF    = 2'd0,
    M_GATED  = 2'd1,
    M_LATCH  = 2'd2,
    M_GLATCH = 2'd3
  } scl_mode_e;

  function automatic scl_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    decode_mode = M_GATED;
      3'd2:    decode_mode = M_LATCH;
      3'd3:    decode_mode = M_GLATCH;
      default: decode_mode = M_OFF;
    endcase
  endfunction
endpackage

// File: rtl/scaler_src_edge.sv
`timescale 1ns/1ps
module scaler_src_edge #(
  parameter int NUM_SRC = 21,
  parameter int SEL_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               rise_o
);
  logic cur, prev_q;

  // out-of-range codes select nothing
  always_comb begin
    cur = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel_i == SEL_W'(i)) cur = src_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;

  assign rise_o = cur & ~prev_q;
endmodule

// File: rtl/scaler_sat_cnt.sv
`timescale 1ns/1ps
module scaler_sat_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             restart_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (restart_i) cnt_q <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;

  assign cnt_o = cnt_q;
endmodule

// File: rtl/scaler_fifo.sv
`timescale 1ns/1ps
module scaler_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [FW-1:0] fill_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [FW-1:0] fill_q;
  logic          do_push, do_pop;

  assign empty_o = (fill_q == '0);
  assign full_o  = (fill_q == FW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i)
    if (do_push && !clr_i) mem[wr_ptr] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end

  assign head_o = mem[rd_ptr];
  assign fill_o = fill_q;
endmodule

// File: rtl/evt_scaler_fifo.sv
`timescale 1ns/1ps
module evt_scaler_fifo
  import scaler_pkg::*;
#(
  parameter int NUM_SRC = 21,
  parameter int SEL_W   = 5,
  parameter int CNT_W   = 32,
  parameter int DEPTH   = 1024,
  localparam int FW     = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_vec_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [3:0]         mode_i,
  input  logic               gate_i,
  input  logic               latch_i,
  input  logic               mreset_i,
  input  logic               sw_reset_i,
  input  logic               rd_en_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic [FW-1:0]      mult_o,
  output logic               overflow_o
);
  scl_mode_e        mode;
  logic             gated, lat_mode, off_mode;
  logic             clr, rise, inc, cnt_en, latch_act, drop;
  logic             gate_q, done_q, ovf_q;
  logic [CNT_W-1:0] count_q, head;
  logic             empty, full;
  logic [FW-1:0]    fill;

  assign mode     = decode_mode(mode_i[2:0]);
  assign gated    = (mode == M_GATED);
  assign lat_mode = (mode == M_LATCH) || (mode == M_GLATCH);
  assign off_mode = (mode == M_OFF);
  assign clr      = sw_reset_i | (mreset_i & mode_i[3]);

  scaler_src_edge #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_vec_i),
    .sel_i  (src_sel_i),
    .rise_o (rise)
  );

  always_comb begin
    case (mode)
      M_GATED:  cnt_en = gate_i & ~done_q;
      M_LATCH:  cnt_en = 1'b1;
      M_GLATCH: cnt_en = gate_i;
      default:  cnt_en = 1'b0;
    endcase
  end

  assign inc       = rise & cnt_en;
  assign latch_act = latch_i & lat_mode;
  assign drop      = latch_act & full;

  scaler_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .restart_i (latch_act),
    .inc_i     (inc),
    .cnt_o     (count_q)
  );

  scaler_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .push_i  (latch_act),
    .wdata_i (count_q),
    .pop_i   (rd_en_i & lat_mode),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full),
    .fill_o  (fill)
  );

  // gate window bookkeeping for single-shot gated mode
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      gate_q <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (clr) begin
        done_q <= 1'b0;
        ovf_q  <= 1'b0;
      end else begin
        if (gated && gate_q && !gate_i) done_q <= 1'b1;
        if (drop) ovf_q <= 1'b1;
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rd_data_o <= '0;
    else if (rd_en_i) begin
      if (gated)                  rd_data_o <= count_q;
      else if (lat_mode && !empty) rd_data_o <= head;
      else                        rd_data_o <= '0;
    end

  assign mult_o     = gated ? FW'(1) : (lat_mode ? fill : '0);
  assign overflow_o = ovf_q;
endmodule

// File: rtl/evt_scaler_fifo_chk.sv
`timescale 1ns/1ps
module evt_scaler_fifo_chk #(
  parameter int CNT_W = 32,
  parameter int DEPTH = 1024,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr,
  input logic             gated,
  input logic             off_mode,
  input logic             gate_i,
  input logic             done_q,
  input logic             latch_act,
  input logic [CNT_W-1:0] count_q,
  input logic [FW-1:0]    fill,
  input logic [FW-1:0]    mult_o,
  input logic             overflow_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  a_r2_gated_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated && !gate_i && !clr) |=> count_q == $past(count_q));
  a_r2_gated_mult: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated |-> mult_o == FW'(1));
  a_r3_single_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated && done_q && !clr) |=> count_q == $past(count_q));
  a_r6_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= FW'(DEPTH));
  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clr) |=> overflow_o);
  a_r8_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (count_q == '0) && (fill == '0) && !overflow_o);
  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == MAX && !clr && !latch_act) |=> count_q == MAX);
  a_r10_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_mode && !clr) |=> count_q == $past(count_q));
  a_r10_off_mult: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_mode |-> mult_o == '0);
endmodule

bind evt_scaler_fifo evt_scaler_fifo_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr        (clr),
  .gated      (gated),
  .off_mode   (off_mode),
  .gate_i     (gate_i),
  .done_q     (done_q),
  .latch_act  (latch_act),
  .count_q    (count_q),
  .fill       (fill),
  .mult_o     (mult_o),
  .overflow_o (overflow_o)
);

// File: tb/evt_scaler_fifo_tb.sv
`timescale 1ns/1ps
module evt_scaler_fifo_tb;
  localparam int NUM_SRC = 21;
  localparam int SEL_W   = 5;
  localparam int CNT_W   = 8;
  localparam int DEPTH   = 8;
  localparam int FW      = $clog2(DEPTH + 1);

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NUM_SRC-1:0] src_vec = '0;
  logic [SEL_W-1:0]   src_sel = '0;
  logic [3:0]         mode = 4'd0;
  logic               gate = 1'b0, latch = 1'b0, mreset = 1'b0, sw_reset = 1'b0, rd_en = 1'b0;
  logic [CNT_W-1:0]   rd_data;
  logic [FW-1:0]      mult;
  logic               ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  evt_scaler_fifo #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_vec_i(src_vec), .src_sel_i(src_sel),
    .mode_i(mode), .gate_i(gate), .latch_i(latch), .mreset_i(mreset),
    .sw_reset_i(sw_reset), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .mult_o(mult), .overflow_o(ovf)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pulses(input logic [NUM_SRC-1:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      src_vec = m; @(negedge clk);
      src_vec = '0; @(negedge clk);
    end
  endtask

  task automatic do_latch();
    latch = 1'b1; @(negedge clk); latch = 1'b0;
  endtask

  task automatic do_swrst();
    sw_reset = 1'b1; @(negedge clk); sw_reset = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int exp);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check(tag, int'(rd_data), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 reset mult", int'(mult), 0);
    check("R7 reset overflow", int'(ovf), 0);
    rd_chk("R10 reset read", 0);

    // R1: sweep every select code in latched mode
    mode = 4'd2;
    for (int s = 0; s < 32; s++) begin
      int n;
      logic [NUM_SRC-1:0] own, others;
      do_swrst();
      src_sel = SEL_W'(s);
      n = (s % 3) + 1;
      own = '0;
      if (s < NUM_SRC) own[s] = 1'b1;
      others = ~own;
      pulses(own, n);
      pulses(others, 1);
      src_vec = own; @(negedge clk); @(negedge clk); src_vec = '0; @(negedge clk);
      do_latch();
      rd_chk($sformatf("R1 sel %0d", s), (s < NUM_SRC) ? n + 1 : 0);
    end
    src_sel = '0;

    // R2 gated counting and non-destructive read
    mode = 4'd1; gate = 1'b0; do_swrst();
    gate = 1'b1; @(negedge clk);
    pulses(21'h1, 3);
    gate = 1'b0; @(negedge clk);
    pulses(21'h1, 2);
    rd_chk("R2 gated count", 3);
    rd_chk("R2 gated reread", 3);
    check("R2 gated mult", int'(mult), 1);
    // R3 second gate ignored until reset
    gate = 1'b1; @(negedge clk);
    pulses(21'h1, 2);
    gate = 1'b0; @(negedge clk);
    rd_chk("R3 second gate", 3);
    do_swrst();
    gate = 1'b1; @(negedge clk);
    pulses(21'h1, 1);
    gate = 1'b0; @(negedge clk);
    rd_chk("R3 after reset", 1);

    // R4 / R6 latched intervals
    mode = 4'd2; do_swrst();
    pulses(21'h1, 2); do_latch();
    pulses(21'h1, 5); do_latch();
    do_latch();
    check("R6 mult three", int'(mult), 3);
    rd_chk("R4 word 0", 2);
    rd_chk("R4 word 1", 5);
    rd_chk("R4 word 2", 0);
    check("R6 mult empty", int'(mult), 0);
    rd_chk("R6 empty read", 0);
    pulses(21'h1, 4);
    src_vec = 21'h1; latch = 1'b1; @(negedge clk);
    src_vec = '0; latch = 1'b0; @(negedge clk);
    do_latch();
    rd_chk("R4 before latch edge", 4);
    rd_chk("R4 latch-cycle edge", 1);

    // R5 gated-latched
    mode = 4'd3; do_swrst();
    gate = 1'b0; pulses(21'h1, 3);
    gate = 1'b1; pulses(21'h1, 2);
    gate = 1'b0; pulses(21'h1, 4);
    do_latch();
    rd_chk("R5 gated-latched", 2);

    // R7 overflow
    mode = 4'd2; do_swrst();
    for (int i = 0; i < DEPTH; i++) begin
      pulses(21'h1, i); do_latch();
    end
    check("R7 full mult", int'(mult), DEPTH);
    check("R7 no overflow yet", int'(ovf), 0);
    pulses(21'h1, 3); do_latch();
    check("R7 overflow set", int'(ovf), 1);
    check("R7 mult stays", int'(mult), DEPTH);
    rd_chk("R7 oldest", 0);
    pulses(21'h1, 2); do_latch();
    for (int i = 1; i < DEPTH; i++) rd_chk($sformatf("R7 word %0d", i), i);
    rd_chk("R7 restart after drop", 2);
    check("R7 overflow sticky", int'(ovf), 1);

    // R8 resets
    pulses(21'h1, 1); do_latch();
    mreset = 1'b1; @(negedge clk); mreset = 1'b0;
    check("R8 mreset masked mult", int'(mult), 1);
    check("R8 mreset masked ovf", int'(ovf), 1);
    mode = 4'b1010;
    mreset = 1'b1; @(negedge clk); mreset = 1'b0;
    check("R8 mreset mult", int'(mult), 0);
    check("R8 mreset ovf", int'(ovf), 0);
    pulses(21'h1, 3); do_swrst(); do_latch();
    rd_chk("R8 swrst count", 0);

    // R9 saturation
    mode = 4'd2; do_swrst();
    pulses(21'h1, 300); do_latch();
    rd_chk("R9 saturate", 255);

    // R10 off modes
    for (int m = 0; m < 8; m++) begin
      if (m >= 1 && m <= 3) continue;
      mode = 4'd2; do_swrst();
      mode = 4'(m);
      pulses(21'h1, 3); do_latch();
      check($sformatf("R10 mode %0d mult", m), int'(mult), 0);
      rd_chk($sformatf("R10 mode %0d read", m), 0);
      mode = 4'd2; @(negedge clk);
      check($sformatf("R10 mode %0d no push", m), int'(mult), 0);
      do_latch();
      rd_chk($sformatf("R10 mode %0d held", m), 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule